// File: doc/BRIEF.md
# Serial Register Address Receiver

This block sits on the slave side of a slotted backplane and decides which of a module's internal registers the host is talking to. The host keeps the slot select low and holds the data/address strobe high. It then clocks a 16-bit register address onto a single serial data line, one bit per rising edge of the serial clock, with the most significant bit first.

When the host pulls the data/address strobe low, the address phase ends. The block decodes the captured word and raises exactly one register select, or none if the word matches no register. Register 0 is the module identity register and register 1 is the data register. Further registers follow at consecutive addresses when `NUM_REGS` is raised.

All serial inputs are asynchronous to the system clock. They pass through a synchroniser of `SYNC_STAGES` flops, and serial clock edges are detected in the system clock domain. A select appears `SYNC_STAGES + 1` system clocks after the strobe falls at the pins. At 125 MHz with the default two stages this is 24 ns, well inside the 425 ns the host leaves between its last serial clock edge and the strobe.

Top module: `sah_addr_slave`

## Requirements
- R1: While reset is active and in the first cycles after it, `reg_sel` is all zero and `addr_q` is zero.
- R2: A falling serial clock edge, or a serial clock held low, leaves `addr_q` unchanged. Only a low-to-high transition shifts a bit in.
- R3: Bits enter at the least significant end, so after 16 rising edges `addr_q` equals the 16-bit word sent most significant bit first.
- R4: After address 0x0001 is captured, a falling data/address strobe with the slot selected raises only `reg_sel[1]` (the data register).
- R5: After address 0x0000 is captured, a falling strobe raises only `reg_sel[0]` (the identity register).
- R6: A captured address of `NUM_REGS` or above leaves `reg_sel` all zero after the strobe falls.
- R7: Driving the slot select high clears both `addr_q` and `reg_sel`.
- R8: Rising serial clock edges while the strobe is low do not change `addr_q`.
- R9: `reg_sel` has at most one bit set. It returns to zero once the strobe goes high again.
- R10: A select changes exactly `SYNC_STAGES + 1` system clock cycles after the strobe edge at the pins. A shift changes exactly `SYNC_STAGES + 1` cycles after the rising serial clock edge at the pins.
- R11: Serial clock edges while the slot select is high leave `addr_q` at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_sel_n | input | 1 | Slot select, active low, asynchronous |
| ser_clk | input | 1 | Serial clock from the host, idles high, asynchronous |
| ser_din | input | 1 | Serial address data, asynchronous |
| da_line | input | 1 | Data/address strobe: high for the address phase, falling edge commits |
| reg_sel | output | NUM_REGS | One-hot register select |
| addr_q | output | ADDR_W | Address captured so far |

## Verification
The assertions check on every cycle that the select is never more than one-hot. They also check that a select only appears after a strobe fall and only for an address inside the register range, that an inactive slot clears everything, and that the address holds still through the data phase.

Only the bench scenarios can show the remaining properties. These are that the bit order is most significant first, that particular words pick the identity or the data register, and that falling serial clock edges and clock activity with the slot deselected are ignored. The bench's clock-by-clock reference model shows that every change lands in exactly the cycle the synchroniser depth predicts.

// File: rtl/sah_pkg.sv
package sah_pkg;

   // Synchronised view of the asynchronous serial pins
   typedef struct packed {
      logic slot_n;
      logic sclk;
      logic sdin;
      logic da;
   } sah_pins_t;

   localparam int PINS_W = $bits(sah_pins_t);

   // Idle levels: slot deselected, clock high, data low, strobe high
   localparam sah_pins_t PINS_IDLE = '{slot_n: 1'b1, sclk: 1'b1, sdin: 1'b0, da: 1'b1};

endpackage

// File: rtl/sah_sync.sv
module sah_sync #(
   parameter int            W      = 4,
   parameter int            STAGES = 2,
   parameter logic [W-1:0]  RST_V  = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [W-1:0] pipe [STAGES];

   genvar s;
   generate
      for (s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) pipe[s] <= RST_V;
               else        pipe[s] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) pipe[s] <= RST_V;
               else        pipe[s] <= pipe[s-1];
            end
         end
      end
   endgenerate

   assign q = pipe[STAGES-1];

endmodule

// File: rtl/sah_shift.sv
module sah_shift #(
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              slot_on,
   input  logic              addr_phase,
   input  logic              sclk,
   input  logic              sdin,
   output logic [ADDR_W-1:0] addr
);

   logic sclk_d;
   logic sclk_rise;

   assign sclk_rise = sclk & ~sclk_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_d <= 1'b1;
      else        sclk_d <= sclk;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr <= '0;
      end else if (!slot_on) begin
         addr <= '0;
      end else if (addr_phase && sclk_rise) begin
         addr <= {addr[ADDR_W-2:0], sdin};
      end
   end

endmodule

// File: rtl/sah_decode.sv
module sah_decode #(
   parameter int ADDR_W   = 16,
   parameter int NUM_REGS = 2
) (
   input  logic [ADDR_W-1:0]   addr,
   output logic [NUM_REGS-1:0] hit
);

   genvar k;
   generate
      for (k = 0; k < NUM_REGS; k++) begin : g_hit
         assign hit[k] = (addr == ADDR_W'(k));
      end
   endgenerate

endmodule

// File: rtl/sah_addr_slave.sv
module sah_addr_slave #(
   parameter int ADDR_W      = 16,
   parameter int NUM_REGS    = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                slot_sel_n,
   input  logic                ser_clk,
   input  logic                ser_din,
   input  logic                da_line,
   output logic [NUM_REGS-1:0] reg_sel,
   output logic [ADDR_W-1:0]   addr_q
);
   import sah_pkg::*;

   generate
      if (ADDR_W < 2) begin : g_bad_width
         $error("sah_addr_slave: ADDR_W must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("sah_addr_slave: SYNC_STAGES must be at least 2");
      end
      if (NUM_REGS < 1 || NUM_REGS > 64) begin : g_bad_regs
         $error("sah_addr_slave: NUM_REGS must lie in 1..64");
      end
   endgenerate

   sah_pins_t pins_raw;
   sah_pins_t pins_s;
   logic [PINS_W-1:0] pins_q;

   assign pins_raw = '{slot_n: slot_sel_n, sclk: ser_clk, sdin: ser_din, da: da_line};

   sah_sync #(
      .W      (PINS_W),
      .STAGES (SYNC_STAGES),
      .RST_V  (PINS_IDLE)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pins_raw),
      .q     (pins_q)
   );

   assign pins_s = sah_pins_t'(pins_q);

   logic slot_on;
   logic da_s;
   logic da_d;
   logic da_fall;
   logic addr_phase;

   assign slot_on    = ~pins_s.slot_n;
   assign da_s       = pins_s.da;
   assign addr_phase = slot_on & da_s;
   assign da_fall    = slot_on & da_d & ~da_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) da_d <= 1'b1;
      else        da_d <= da_s;
   end

   sah_shift #(
      .ADDR_W (ADDR_W)
   ) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .slot_on    (slot_on),
      .addr_phase (addr_phase),
      .sclk       (pins_s.sclk),
      .sdin       (pins_s.sdin),
      .addr       (addr_q)
   );

   logic [NUM_REGS-1:0] hit;

   sah_decode #(
      .ADDR_W   (ADDR_W),
      .NUM_REGS (NUM_REGS)
   ) u_dec (
      .addr (addr_q),
      .hit  (hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_sel <= '0;
      end else if (!slot_on || da_s) begin
         reg_sel <= '0;
      end else if (da_fall) begin
         reg_sel <= hit;
      end
   end

endmodule

// File: rtl/sah_checks.sv
module sah_checks #(
   parameter int ADDR_W   = 16,
   parameter int NUM_REGS = 2
) (
   input logic                clk,
   input logic                rst_n,
   input logic                slot_on,
   input logic                da_s,
   input logic                da_fall,
   input logic [NUM_REGS-1:0] reg_sel,
   input logic [ADDR_W-1:0]   addr_q
);

   localparam logic [ADDR_W-1:0] LAST_REG = ADDR_W'(NUM_REGS - 1);

   // R9: never more than one register selected
   assert_sel_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(reg_sel));

   // R7: an inactive slot leaves nothing captured and nothing selected
   assert_slot_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !slot_on |=> (reg_sel == '0 && addr_q == '0));

   // R8: data phase holds the captured address
   assert_addr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(slot_on && !da_s) |-> $stable(addr_q));

   // R4: a select only appears right after a strobe fall
   assert_sel_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(|reg_sel) |-> $past(da_fall));

   // R6: a select implies an address inside the register range
   assert_sel_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (|reg_sel) |-> (addr_q <= LAST_REG));

   // R9: address phase leaves no select standing
   assert_sel_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_on && da_s) |=> (reg_sel == '0));

endmodule

bind sah_addr_slave sah_checks #(
   .ADDR_W   (ADDR_W),
   .NUM_REGS (NUM_REGS)
) u_checks (
   .clk     (clk),
   .rst_n   (rst_n),
   .slot_on (slot_on),
   .da_s    (da_s),
   .da_fall (da_fall),
   .reg_sel (reg_sel),
   .addr_q  (addr_q)
);

// File: tb/sah_addr_slave_test.sv
module sah_addr_slave_test;

   localparam int ADDR_W = 16;
   localparam int NREG   = 2;
   localparam int SYNC   = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic slot_sel_n = 1'b1;
   logic ser_clk = 1'b1;
   logic ser_din = 1'b0;
   logic da_line = 1'b1;
   logic [NREG-1:0]   reg_sel;
   logic [ADDR_W-1:0] addr_q;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   sah_addr_slave #(.ADDR_W(ADDR_W), .NUM_REGS(NREG), .SYNC_STAGES(SYNC)) uut (
      .clk(clk), .rst_n(rst_n), .slot_sel_n(slot_sel_n), .ser_clk(ser_clk),
      .ser_din(ser_din), .da_line(da_line), .reg_sel(reg_sel), .addr_q(addr_q));

   // Behavioural reference: pin history queue, delayed by the sync depth
   logic [3:0] hist[$];
   logic [ADDR_W-1:0] m_addr;
   logic [NREG-1:0]   m_sel;

   always @(posedge clk) begin
      logic [3:0] cur, prv;
      if (!rst_n) begin
         hist = {};
         for (int i = 0; i < SYNC + 2; i++) hist.push_front(4'b1101);
         m_addr = '0;
         m_sel  = '0;
      end else begin
         hist.push_front({slot_sel_n, ser_clk, ser_din, da_line});
         if (hist.size() > SYNC + 2) void'(hist.pop_back());
         cur = hist[SYNC];
         prv = hist[SYNC+1];
         if (cur[3]) begin
            m_addr = '0;
            m_sel  = '0;
         end else if (cur[0]) begin
            m_sel = '0;
            if (cur[2] && !prv[2]) m_addr = {m_addr[ADDR_W-2:0], cur[1]};
         end else if (prv[0]) begin
            m_sel = '0;
            if (int'(m_addr) < NREG) m_sel[m_addr] = 1'b1;
         end
      end
   end

   task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
      end
   endtask

   // R10: every cycle the outputs follow the reference exactly
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check("R10 sel timing", 32'(reg_sel), 32'(m_sel));
         check("R10 addr timing", 32'(addr_q), 32'(m_addr));
      end
   end

   task automatic wait_clk(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send_word(logic [ADDR_W-1:0] w);
      for (int b = ADDR_W - 1; b >= 0; b--) begin
         ser_din = w[b];
         ser_clk = 1'b0;
         wait_clk(3);
         ser_clk = 1'b1;
         wait_clk(3);
      end
      wait_clk(6);
   endtask

   initial begin
      #(8 * 100000);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      wait_clk(4);
      check("R1 reset sel", 32'(reg_sel), 0);
      check("R1 reset addr", 32'(addr_q), 0);
      rst_n = 1'b1;
      wait_clk(3);
      check("R1 post-reset sel", 32'(reg_sel), 0);

      slot_sel_n = 1'b0;
      wait_clk(4);
      send_word(16'h0001);
      check("R3 word 0001", 32'(addr_q), 32'h0001);
      da_line = 1'b0;
      wait_clk(6);
      check("R4 data reg select", 32'(reg_sel), 32'b10);

      // R8: clocking while the strobe is low
      ser_din = 1'b1;
      for (int i = 0; i < 4; i++) begin
         ser_clk = 1'b0; wait_clk(3);
         ser_clk = 1'b1; wait_clk(3);
      end
      check("R8 addr held in data phase", 32'(addr_q), 32'h0001);

      da_line = 1'b1;
      wait_clk(6);
      check("R9 sel dropped", 32'(reg_sel), 0);

      send_word(16'h0000);
      da_line = 1'b0;
      wait_clk(6);
      check("R5 id reg select", 32'(reg_sel), 32'b01);
      da_line = 1'b1;
      wait_clk(6);

      send_word(16'hA5C3);
      check("R3 word A5C3", 32'(addr_q), 32'hA5C3);
      da_line = 1'b0;
      wait_clk(6);
      check("R6 no select", 32'(reg_sel), 0);
      da_line = 1'b1;
      wait_clk(6);

      // R2: falling edge alone does not shift
      ser_din = 1'b0;
      ser_clk = 1'b0;
      wait_clk(8);
      check("R2 fall no shift", 32'(addr_q), 32'hA5C3);
      ser_clk = 1'b1;
      wait_clk(6);
      check("R2 rise shifts", 32'(addr_q), 32'h4B86);

      send_word(16'h0001);
      da_line = 1'b0;
      wait_clk(6);
      slot_sel_n = 1'b1;
      wait_clk(6);
      check("R7 sel cleared", 32'(reg_sel), 0);
      check("R7 addr cleared", 32'(addr_q), 0);

      // R11: clocks with slot deselected
      da_line = 1'b1;
      ser_din = 1'b1;
      for (int i = 0; i < 5; i++) begin
         ser_clk = 1'b0; wait_clk(3);
         ser_clk = 1'b1; wait_clk(3);
      end
      check("R11 idle slot addr", 32'(addr_q), 0);

      wait_clk(4);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule